// File: doc/BRIEF.md
# Outbound Configuration Address Translator

This block holds one outbound address-translation region and a helper that sets up configuration accesses through it. Software programs the region through a small register window: a selector that names the region being edited, a transaction-type field, an enable bit, a base, a limit and a target. Every address on the lookup port is compared with the enabled window. An address inside the window is moved to the target space and tagged with the region's type. An address outside it passes through unchanged and carries a miss flag.

The helper takes a bus, device, function and register offset. It rejects devices that cannot sit directly under a root port. For an accepted request it retypes the region as a type 0 or type 1 configuration access, depending on the bus number. It loads the target with the packed bus, device and function, and returns the address the access should be issued to. Bus 0 accesses go to local registers and skip the window. Only outbound region 0 and 32-bit addresses are handled.

Top module: `obx_xlat_top`

## Requirements
- R1: After reset the selector, type, enable, base, limit and target are all zero, the lookup and configuration outputs are not valid, and every register offset reads zero.
- R2: Register offsets: 0x900 selector (bit 31 direction, 1 = inbound; bits [3:0] region index), 0x904 type in bits [2:0], 0x908 enable in bit 31, 0x90C base, 0x914 limit, 0x918 target. Offsets 0x910 and 0x91C and all unmapped offsets read zero, and writes to them are dropped. Mapped fields read back what was written.
- R3: Writes to type, enable, base, limit and target are ignored unless the selector holds direction 0 and index 0. The selector itself is always writable.
- R4: A lookup on an enabled region with base <= address <= limit hits. One cycle later the result is valid with address target + (address - base), the type from 0x904, and miss low.
- R5: A lookup that is outside the window, or made while the region is disabled, gives the input address unchanged, type 0 and miss high, one cycle later.
- R6: A register write takes effect for lookups presented in the following cycle. A lookup presented in the same cycle as the write uses the old values.
- R7: A configuration request is rejected when the bus is 0 and the device is above 1, or the bus is 1 and the device is above 0. A rejected request leaves all region fields unchanged. Its response has ok low, and the data is 0xFFFFFFFF for a read and 0 for a write.
- R8: An accepted request sets the type to 4 (type 0 configuration) for buses 0 and 1, and to 5 (type 1 configuration) for bus 2 and above. It also resets the selector to outbound index 0.
- R9: An accepted request on a nonzero bus loads the target with bus in [31:24], device in [23:19] and function in [18:16], and returns the configuration-window base plus the offset rounded down to 4 bytes. A bus 0 request leaves the target alone, flags the response local, and returns the local-register base plus the rounded offset.
- R10: When a configuration request and a register write arrive in the same cycle, the request's update to the type, target and selector takes priority.
- R11: The configuration response is valid exactly one cycle after each request. Accepted responses carry data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| lk_vld | input | 1 | Lookup request valid |
| lk_addr | input | 32 | Lookup address |
| lk_out_vld | output | 1 | Lookup result valid |
| lk_out_addr | output | 32 | Translated or passed-through address |
| lk_out_type | output | 3 | Transaction type tag |
| lk_out_miss | output | 1 | Address fell outside the enabled window |
| cfg_req | input | 1 | Configuration access request |
| cfg_wr | input | 1 | Request is a write (1) or read (0) |
| cfg_bus | input | 8 | Bus number |
| cfg_dev | input | 5 | Device number |
| cfg_func | input | 3 | Function number |
| cfg_off | input | 12 | Register offset within the function |
| cfg_rsp_vld | output | 1 | Configuration response valid |
| cfg_rsp_ok | output | 1 | Request accepted |
| cfg_rsp_local | output | 1 | Access targets local registers (bus 0) |
| cfg_rsp_addr | output | 32 | Address to issue the access to |
| cfg_rsp_rdata | output | 32 | Fill data: all ones for a rejected read |

## Verification
The hardest case to reach from the ports is a configuration request and a software register write landing in the same cycle. The stimulus drives both on one falling edge and then reads the type field back. The same-cycle ordering between a region write and a lookup is tested the same way: the base is moved while a lookup is in flight, and the following lookup is checked against the new bounds. Exact boundary addresses at base, at limit and one past each end are taken from a vector table.

// File: rtl/obx_pkg.sv
`timescale 1ns/1ps
// obx_pkg: shared offsets, type codes and the region state record.
// Assumes 32-bit addresses and a 12-bit register offset space.
package obx_pkg;
    localparam int AW    = 32;
    localparam int OFF_W = 12;
    localparam int IDX_W = 4;

    localparam logic [OFF_W-1:0] OFF_SEL   = 12'h900;
    localparam logic [OFF_W-1:0] OFF_TYPE  = 12'h904;
    localparam logic [OFF_W-1:0] OFF_EN    = 12'h908;
    localparam logic [OFF_W-1:0] OFF_BASE  = 12'h90C;
    localparam logic [OFF_W-1:0] OFF_UBASE = 12'h910;
    localparam logic [OFF_W-1:0] OFF_LIM   = 12'h914;
    localparam logic [OFF_W-1:0] OFF_TGT   = 12'h918;
    localparam logic [OFF_W-1:0] OFF_UTGT  = 12'h91C;

    localparam logic [2:0] TY_MEM  = 3'd0;
    localparam logic [2:0] TY_IO   = 3'd2;
    localparam logic [2:0] TY_CFG0 = 3'd4;
    localparam logic [2:0] TY_CFG1 = 3'd5;

    typedef struct packed {
        logic             dir_in;
        logic [IDX_W-1:0] idx;
        logic [2:0]       typ;
        logic             en;
        logic [AW-1:0]    base;
        logic [AW-1:0]    lim;
        logic [AW-1:0]    tgt;
    } region_t;
endpackage

// File: rtl/obx_regs.sv
`timescale 1ns/1ps
// obx_regs: register window for the single outbound region.
// Region fields change only while the selector names outbound index 0.
// A configuration-helper update overrides a same-cycle software write.
module obx_regs
    import obx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [OFF_W-1:0] addr,
    input  logic [AW-1:0]    wdata,
    output logic [AW-1:0]    rdata,
    input  logic             cfg_upd,
    input  logic [2:0]       cfg_type,
    input  logic             cfg_tgt_we,
    input  logic [AW-1:0]    cfg_tgt,
    output region_t          region
);
    region_t r_q;
    logic    sel0;

    // Region fields are editable only through outbound index 0.
    assign sel0   = !r_q.dir_in && (r_q.idx == '0);
    assign region = r_q;

    // Field update: reset, helper override, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else if (cfg_upd) begin
            r_q.dir_in <= 1'b0;
            r_q.idx    <= '0;
            r_q.typ    <= cfg_type;
            if (cfg_tgt_we) r_q.tgt <= cfg_tgt;
        end else if (wr) begin
            if (addr == OFF_SEL) begin
                r_q.dir_in <= wdata[AW-1];
                r_q.idx    <= wdata[IDX_W-1:0];
            end else if (sel0) begin
                case (addr)
                    OFF_TYPE: r_q.typ  <= wdata[2:0];
                    OFF_EN:   r_q.en   <= wdata[AW-1];
                    OFF_BASE: r_q.base <= wdata;
                    OFF_LIM:  r_q.lim  <= wdata;
                    OFF_TGT:  r_q.tgt  <= wdata;
                    default:  ;
                endcase
            end
        end
    end

    // Read mux; upper halves and unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            OFF_SEL:  rdata = {r_q.dir_in, {(AW-1-IDX_W){1'b0}}, r_q.idx};
            OFF_TYPE: rdata = {{(AW-3){1'b0}}, r_q.typ};
            OFF_EN:   rdata = {r_q.en, {(AW-1){1'b0}}};
            OFF_BASE: rdata = r_q.base;
            OFF_LIM:  rdata = r_q.lim;
            OFF_TGT:  rdata = r_q.tgt;
            default:  rdata = '0;
        endcase
    end

    // R3
    ignore_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !cfg_upd && !sel0 && addr == OFF_BASE) |=> $stable(r_q.base));

    // R10
    cfg_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_upd |=> (r_q.typ == $past(cfg_type)) && !r_q.dir_in);
endmodule

// File: rtl/obx_lookup.sv
`timescale 1ns/1ps
// obx_lookup: one-cycle window match and remap for the outbound region.
// Uses the region state as it stands before the capturing edge.
module obx_lookup
    import obx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  region_t       region,
    input  logic          in_vld,
    input  logic [AW-1:0] in_addr,
    output logic          out_vld,
    output logic [AW-1:0] out_addr,
    output logic [2:0]    out_type,
    output logic          out_miss
);
    logic          hit;
    logic [AW-1:0] moved;

    // Window test, inclusive at both ends, gated by the enable.
    assign hit   = region.en && (in_addr >= region.base) && (in_addr <= region.lim);
    assign moved = region.tgt + (in_addr - region.base);

    // Register the result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_addr <= '0;
            out_type <= '0;
            out_miss <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_addr <= hit ? moved : in_addr;
                out_type <= hit ? region.typ : TY_MEM;
                out_miss <= !hit;
            end
        end
    end

    // R4
    lk_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    // R5
    off_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !region.en) |=> (out_miss && out_type == TY_MEM));
endmodule

// File: rtl/obx_cfg_helper.sv
`timescale 1ns/1ps
// obx_cfg_helper: validates a configuration request, drives the region
// retype and target update, and registers the response.
// Assumes a root port: bus 0 holds devices 0..1, bus 1 holds device 0.
module obx_cfg_helper
    import obx_pkg::*;
#(
    parameter logic [AW-1:0] LOCAL_BASE = 32'h01FF_C000,
    parameter logic [AW-1:0] CFG_WIN    = 32'h01F0_0000
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic [7:0]       bus,
    input  logic [4:0]       dev,
    input  logic [2:0]       func,
    input  logic [OFF_W-1:0] off,
    output logic             upd,
    output logic [2:0]       upd_type,
    output logic             tgt_we,
    output logic [AW-1:0]    tgt,
    output logic             rsp_vld,
    output logic             rsp_ok,
    output logic             rsp_local,
    output logic [AW-1:0]    rsp_addr,
    output logic [AW-1:0]    rsp_rdata
);
    localparam int PAD = AW - OFF_W;

    logic          bad;
    logic          on_bus0;
    logic [AW-1:0] off_al;

    // Reachability rule and the derived region update.
    assign on_bus0  = (bus == 8'd0);
    assign bad      = (on_bus0 && dev > 5'd1) || (bus == 8'd1 && dev != 5'd0);
    assign upd      = req && !bad;
    assign upd_type = (bus < 8'd2) ? TY_CFG0 : TY_CFG1;
    assign tgt_we   = upd && !on_bus0;
    assign tgt      = {bus, dev, func, 16'h0000};
    assign off_al   = {{PAD{1'b0}}, off[OFF_W-1:2], 2'b00};

    // Response register, valid the cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld   <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_local <= 1'b0;
            rsp_addr  <= '0;
            rsp_rdata <= '0;
        end else begin
            rsp_vld <= req;
            if (req) begin
                rsp_ok    <= !bad;
                rsp_local <= on_bus0;
                rsp_addr  <= (on_bus0 ? LOCAL_BASE : CFG_WIN) + off_al;
                rsp_rdata <= (bad && !wr) ? '1 : '0;
            end
        end
    end

    // R11
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> rsp_vld);

    // R7
    reject_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !wr && bad) |=> (!rsp_ok && rsp_rdata == '1));
endmodule

// File: rtl/obx_xlat_top.sv
`timescale 1ns/1ps
// obx_xlat_top: outbound region 0 translator with configuration helper.
// Assumes 32-bit addresses; inbound regions and packet build live elsewhere.
module obx_xlat_top
    import obx_pkg::*;
#(
    parameter logic [31:0] LOCAL_BASE = 32'h01FF_C000,
    parameter logic [31:0] CFG_WIN    = 32'h01F0_0000
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        lk_vld,
    input  logic [31:0] lk_addr,
    output logic        lk_out_vld,
    output logic [31:0] lk_out_addr,
    output logic [2:0]  lk_out_type,
    output logic        lk_out_miss,
    input  logic        cfg_req,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_bus,
    input  logic [4:0]  cfg_dev,
    input  logic [2:0]  cfg_func,
    input  logic [11:0] cfg_off,
    output logic        cfg_rsp_vld,
    output logic        cfg_rsp_ok,
    output logic        cfg_rsp_local,
    output logic [31:0] cfg_rsp_addr,
    output logic [31:0] cfg_rsp_rdata
);
    region_t       region;
    logic          upd;
    logic [2:0]    upd_type;
    logic          tgt_we;
    logic [AW-1:0] tgt;

    obx_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cfg_upd(upd),
        .cfg_type(upd_type), .cfg_tgt_we(tgt_we), .cfg_tgt(tgt),
        .region(region)
    );

    obx_lookup u_lookup (
        .clk(clk), .rst_n(rst_n), .region(region), .in_vld(lk_vld),
        .in_addr(lk_addr), .out_vld(lk_out_vld), .out_addr(lk_out_addr),
        .out_type(lk_out_type), .out_miss(lk_out_miss)
    );

    obx_cfg_helper #(.LOCAL_BASE(LOCAL_BASE), .CFG_WIN(CFG_WIN)) u_cfg (
        .clk(clk), .rst_n(rst_n), .req(cfg_req), .wr(cfg_wr),
        .bus(cfg_bus), .dev(cfg_dev), .func(cfg_func), .off(cfg_off),
        .upd(upd), .upd_type(upd_type), .tgt_we(tgt_we), .tgt(tgt),
        .rsp_vld(cfg_rsp_vld), .rsp_ok(cfg_rsp_ok),
        .rsp_local(cfg_rsp_local), .rsp_addr(cfg_rsp_addr),
        .rsp_rdata(cfg_rsp_rdata)
    );

    // R8
    cfg1_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_bus >= 8'd2) |=> (region.typ == TY_CFG1));

    // R9
    bus0_keeps_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_bus == 8'd0 && !reg_wr) |=> $stable(region.tgt));
endmodule

// File: tb/obx_xlat_top_bench.sv
`timescale 1ns/1ps
module obx_xlat_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_vld = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_out_vld;
    logic [31:0] lk_out_addr;
    logic [2:0]  lk_out_type;
    logic        lk_out_miss;
    logic        cfg_req = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_bus = '0;
    logic [4:0]  cfg_dev = '0;
    logic [2:0]  cfg_func = '0;
    logic [11:0] cfg_off = '0;
    logic        cfg_rsp_vld, cfg_rsp_ok, cfg_rsp_local;
    logic [31:0] cfg_rsp_addr, cfg_rsp_rdata;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    obx_xlat_top u_obx_xlat_top (.*);

    // {expect miss, lookup address, expected output address}
    localparam logic [64:0] VEC [0:6] = '{
        {1'b0, 32'h1000_0000, 32'h8000_0000},
        {1'b0, 32'h1000_FFFF, 32'h8000_FFFF},
        {1'b1, 32'h0FFF_FFFF, 32'h0FFF_FFFF},
        {1'b1, 32'h1001_0000, 32'h1001_0000},
        {1'b0, 32'h1000_1234, 32'h8000_1234},
        {1'b1, 32'h0000_0000, 32'h0000_0000},
        {1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic look(input logic [31:0] a, input logic exp_miss,
                        input logic [31:0] exp_a, input logic [2:0] exp_t, input string tag);
        @(negedge clk);
        lk_vld = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_vld = 1'b0;
        check({tag, " vld"}, {31'd0, lk_out_vld}, 32'd1);
        check({tag, " miss"}, {31'd0, lk_out_miss}, {31'd0, exp_miss});
        check({tag, " addr"}, lk_out_addr, exp_a);
        check({tag, " type"}, {29'd0, lk_out_type}, {29'd0, exp_t});
    endtask

    task automatic cfg(input logic w, input logic [7:0] b, input logic [4:0] d,
                       input logic [2:0] f, input logic [11:0] o, input logic exp_ok,
                       input logic exp_loc, input logic [31:0] exp_a,
                       input logic [31:0] exp_d, input string tag);
        @(negedge clk);
        cfg_req = 1'b1; cfg_wr = w; cfg_bus = b; cfg_dev = d; cfg_func = f; cfg_off = o;
        @(negedge clk);
        cfg_req = 1'b0;
        check({tag, " vld"}, {31'd0, cfg_rsp_vld}, 32'd1);
        check({tag, " ok"}, {31'd0, cfg_rsp_ok}, {31'd0, exp_ok});
        check({tag, " data"}, cfg_rsp_rdata, exp_d);
        if (exp_ok) begin
            check({tag, " local"}, {31'd0, cfg_rsp_local}, {31'd0, exp_loc});
            check({tag, " addr"}, cfg_rsp_addr, exp_a);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 lk_out_vld", {31'd0, lk_out_vld}, 32'd0);
        check("R1 cfg_rsp_vld", {31'd0, cfg_rsp_vld}, 32'd0);
        rd_chk(12'h900, 32'h0, "R1 selector");
        rd_chk(12'h904, 32'h0, "R1 type");
        rd_chk(12'h908, 32'h0, "R1 enable");
        rd_chk(12'h914, 32'h0, "R1 limit");

        // R2 program and read back
        wr_reg(12'h904, 32'h0000_0002);
        wr_reg(12'h90C, 32'h1000_0000);
        wr_reg(12'h914, 32'h1000_FFFF);
        wr_reg(12'h918, 32'h8000_0000);
        wr_reg(12'h908, 32'h8000_0000);
        wr_reg(12'h910, 32'hDEAD_BEEF);
        rd_chk(12'h904, 32'h2, "R2 type");
        rd_chk(12'h90C, 32'h1000_0000, "R2 base");
        rd_chk(12'h914, 32'h1000_FFFF, "R2 limit");
        rd_chk(12'h918, 32'h8000_0000, "R2 target");
        rd_chk(12'h908, 32'h8000_0000, "R2 enable");
        rd_chk(12'h910, 32'h0, "R2 upper base");
        rd_chk(12'h91C, 32'h0, "R2 upper target");

        // R4 R5 table walk
        for (int i = 0; i < 7; i++) begin
            look(VEC[i][63:32], VEC[i][64], VEC[i][31:0],
                 VEC[i][64] ? 3'd0 : 3'd2, VEC[i][64] ? "R5 table" : "R4 table");
        end

        // R6 same-cycle write uses old base, next lookup sees new
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 12'h90C; reg_wdata = 32'h1000_0100;
        lk_vld = 1'b1; lk_addr = 32'h1000_0000;
        @(negedge clk);
        reg_wr = 1'b0; lk_vld = 1'b0;
        check("R6 old base miss", {31'd0, lk_out_miss}, 32'd0);
        check("R6 old base addr", lk_out_addr, 32'h8000_0000);
        look(32'h1000_0000, 1'b1, 32'h1000_0000, 3'd0, "R6 new base");
        look(32'h1000_0100, 1'b0, 32'h8000_0000, 3'd2, "R6 new base hit");

        // R3 writes ignored through other selectors
        wr_reg(12'h900, 32'h0000_0001);
        wr_reg(12'h90C, 32'h2222_0000);
        rd_chk(12'h900, 32'h1, "R3 selector idx");
        rd_chk(12'h90C, 32'h1000_0100, "R3 base kept idx1");
        wr_reg(12'h900, 32'h8000_0000);
        wr_reg(12'h914, 32'h3333_0000);
        rd_chk(12'h914, 32'h1000_FFFF, "R3 limit kept inbound");

        // R5 disabled region never hits
        wr_reg(12'h900, 32'h0);
        wr_reg(12'h908, 32'h0);
        look(32'h1000_0200, 1'b1, 32'h1000_0200, 3'd0, "R5 disabled");

        // R8 R9 bus 3 goes type 1, selector reset from index 2
        wr_reg(12'h900, 32'h0000_0002);
        cfg(1'b0, 8'd3, 5'd2, 3'd5, 12'h10E, 1'b1, 1'b0, 32'h01F0_010C, 32'h0, "R9 bus3");
        rd_chk(12'h918, 32'h0315_0000, "R9 bus3 target");
        rd_chk(12'h904, 32'h5, "R8 bus3 type");
        rd_chk(12'h900, 32'h0, "R8 selector reset");

        // R8 R9 bus 1 device 0 type 0
        cfg(1'b1, 8'd1, 5'd0, 3'd1, 12'h008, 1'b1, 1'b0, 32'h01F0_0008, 32'h0, "R11 bus1");
        rd_chk(12'h918, 32'h0101_0000, "R9 bus1 target");
        rd_chk(12'h904, 32'h4, "R8 bus1 type");

        // R9 bus 0 local, target untouched
        cfg(1'b0, 8'd0, 5'd1, 3'd0, 12'h007, 1'b1, 1'b1, 32'h01FF_C004, 32'h0, "R9 bus0");
        rd_chk(12'h918, 32'h0101_0000, "R9 bus0 target kept");

        // R7 rejections
        cfg(1'b0, 8'd1, 5'd1, 3'd0, 12'h000, 1'b0, 1'b0, 32'h0, 32'hFFFF_FFFF, "R7 bus1 dev1 read");
        cfg(1'b1, 8'd0, 5'd2, 3'd0, 12'h000, 1'b0, 1'b0, 32'h0, 32'h0, "R7 bus0 dev2 write");
        wr_reg(12'h904, 32'h2);
        cfg(1'b0, 8'd0, 5'd3, 3'd0, 12'h000, 1'b0, 1'b0, 32'h0, 32'hFFFF_FFFF, "R7 bus0 dev3 read");
        rd_chk(12'h904, 32'h2, "R7 type kept");
        rd_chk(12'h918, 32'h0101_0000, "R7 target kept");

        // R10 helper beats same-cycle software write
        @(negedge clk);
        cfg_req = 1'b1; cfg_wr = 1'b0; cfg_bus = 8'd2; cfg_dev = 5'd0; cfg_func = 3'd0; cfg_off = 12'h0;
        reg_wr = 1'b1; reg_addr = 12'h904; reg_wdata = 32'h0;
        @(negedge clk);
        cfg_req = 1'b0; reg_wr = 1'b0;
        check("R10 rsp vld", {31'd0, cfg_rsp_vld}, 32'd1);
        rd_chk(12'h904, 32'h5, "R10 type from helper");
        rd_chk(12'h918, 32'h0200_0000, "R10 target from helper");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule